// File: doc/BRIEF.md
# First-Out Alarm Annunciator

This block watches a small set of synchronous fault inputs and keeps evidence of them after they vanish. Every channel owns a sticky fault latch, so a fault that lasts one clock cycle stays visible until a fault reset clears it. Channel 0 is reserved for loss of run proof. It is qualified by the run command, so a missing proof counts as a fault only while the equipment is commanded to run.

On top of the latches sits a first-out recorder. The first latched fault takes first position: its own first-out bit and a global first-out flag are set. After that, later consequence alarms still show in their fault latches but cannot move the recorded cause. A trip request for the safe state follows the global flag. The recorded cause can only be released through a separate first-out reset.

All pins are plain control and status levels. There is no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `fo_annunciator`

## Requirements
- R1: Channel 0's fault latch sets on any clock edge where `run_cmd_i` is 1 and `run_proof_i` is 0. It does not set while `run_cmd_i` is 0, whatever the value of the proof input.
- R2: Channel k (k ≥ 1) latches on a rising edge where `alarm_i[k-1]` is 1. A pulse of one cycle is enough, and the latched bit appears in `fault_latched_o[k]` after that edge.
- R3: A latched fault bit stays 1 after its condition clears, until `fault_reset_i` is sampled high. When a reset and a fault condition arrive at the same edge, the reset wins. The fault then latches at the next edge if its condition is still present.
- R4: While no first-out is recorded and `fo_reset_i` is low, any nonzero latch vector causes the next edge to set one bit of `first_out_o` and to set `fo_active_o`.
- R5: While `fo_active_o` is 1 and `fo_reset_i` is low, `first_out_o` does not change. New faults still appear in `fault_latched_o`.
- R6: Sampling `fo_reset_i` high clears `fo_active_o`, `trip_o` and every first-out bit at that edge. Fault latches are left unchanged. A fault that is still latched claims first position again at the following edge.
- R7: When several channels are latched at the edge where first position is claimed, the lowest-numbered one wins. `first_out_o` is always one-hot or all zero.
- R8: `trip_o` rises at the same edge as `fo_active_o` and stays high until a first-out reset.
- R9: A proof input that toggles every cycle while running is captured on its first low sample. The capture is held for as long as the toggling continues.
- R10: Driving `rst_n` low clears all outputs to 0 at once, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_cmd_i | input | 1 | Run command that qualifies the proof fault |
| run_proof_i | input | 1 | Run proof feedback, 1 = proven running |
| alarm_i | input | NUM_CH-1 | Fault conditions for channels 1 to NUM_CH-1, 1 = faulted |
| fault_reset_i | input | 1 | Clears all fault latches |
| fo_reset_i | input | 1 | Clears the first-out record and the trip request |
| fault_latched_o | output | NUM_CH | Sticky per-channel fault bits |
| first_out_o | output | NUM_CH | Per-channel first-out bits, one-hot or zero |
| fo_active_o | output | 1 | Global first-out flag |
| trip_o | output | 1 | Safe-state trip request |

## Verification
The bench builds the default of four channels. This makes every one of the sixteen one-cycle fault patterns small enough to drive exhaustively, so each pattern's latch vector and its lowest-index first-out winner are checked against values computed in the bench. Four channels also give room for directed sequences in which a later fault arrives while first position is held. The remaining cases are run directly: a reset landing on the same edge as a fault, a re-claim after a first-out reset, a proof input toggling every cycle, and an asynchronous reset in the middle of a cycle.

// File: rtl/fo_pkg.sv
package fo_pkg;
  typedef enum logic {
    FO_OPEN   = 1'b0,
    FO_LOCKED = 1'b1
  } fo_state_e;

  localparam int unsigned PROOF_CH = 0;
endpackage

// File: rtl/fo_qualify.sv
module fo_qualify #(
  parameter int unsigned NUM_CH = 4
) (
  input  logic              run_cmd,
  input  logic              run_proof,
  input  logic [NUM_CH-2:0] alarm,
  output logic [NUM_CH-1:0] cond
);
  // Channel 0 is the proof channel; the rest come straight from alarm inputs.
  always_comb begin
    cond[fo_pkg::PROOF_CH] = run_cmd & ~run_proof;
  end

  for (genvar g = 1; g < NUM_CH; g++) begin : g_plain
    assign cond[g] = alarm[g-1];
  end
endmodule

// File: rtl/fo_fault_cell.sv
module fo_fault_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic cond,
  input  logic clr,
  output logic held
);
  // Clear dominates a coincident set.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   held <= 1'b0;
    else if (clr) held <= 1'b0;
    else if (cond) held <= 1'b1;
  end
endmodule

// File: rtl/fo_arbiter.sv
module fo_arbiter #(
  parameter int unsigned NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] latched,
  input  logic              clr,
  output logic [NUM_CH-1:0] first,
  output logic              active,
  output logic              trip
);
  import fo_pkg::*;

  fo_state_e         state_q;
  logic [NUM_CH-1:0] below;
  logic [NUM_CH-1:0] winner;
  logic              claim;

  // below[i]: some lower-numbered channel is latched.
  assign below[0] = 1'b0;
  for (genvar g = 1; g < NUM_CH; g++) begin : g_prio
    assign below[g] = below[g-1] | latched[g-1];
  end
  assign winner = latched & ~below;
  assign claim  = (state_q == FO_OPEN) && (|latched) && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FO_OPEN;
      first   <= '0;
      trip    <= 1'b0;
    end else if (clr) begin
      state_q <= FO_OPEN;
      first   <= '0;
      trip    <= 1'b0;
    end else if (claim) begin
      state_q <= FO_LOCKED;
      first   <= winner;
      trip    <= 1'b1;
    end
  end

  assign active = (state_q == FO_LOCKED);
endmodule

// File: rtl/fo_annunciator.sv
module fo_annunciator #(
  parameter int unsigned NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_cmd_i,
  input  logic              run_proof_i,
  input  logic [NUM_CH-2:0] alarm_i,
  input  logic              fault_reset_i,
  input  logic              fo_reset_i,
  output logic [NUM_CH-1:0] fault_latched_o,
  output logic [NUM_CH-1:0] first_out_o,
  output logic              fo_active_o,
  output logic              trip_o
);
  logic [NUM_CH-1:0] cond;

  fo_qualify #(.NUM_CH(NUM_CH)) u_qual (
    .run_cmd   (run_cmd_i),
    .run_proof (run_proof_i),
    .alarm     (alarm_i),
    .cond      (cond)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_cell
    fo_fault_cell u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .cond  (cond[g]),
      .clr   (fault_reset_i),
      .held  (fault_latched_o[g])
    );
  end

  fo_arbiter #(.NUM_CH(NUM_CH)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .latched (fault_latched_o),
    .clr     (fo_reset_i),
    .first   (first_out_o),
    .active  (fo_active_o),
    .trip    (trip_o)
  );
endmodule

// File: rtl/fo_annunciator_chk.sv
module fo_annunciator_chk #(
  parameter int unsigned NUM_CH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run_cmd_i,
  input logic              run_proof_i,
  input logic [NUM_CH-2:0] alarm_i,
  input logic              fault_reset_i,
  input logic              fo_reset_i,
  input logic [NUM_CH-1:0] fault_latched_o,
  input logic [NUM_CH-1:0] first_out_o,
  input logic              fo_active_o,
  input logic              trip_o
);
  p_proof_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (run_cmd_i && !run_proof_i && !fault_reset_i) |=> fault_latched_o[0]);

  p_alarm_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_reset_i |=> ((fault_latched_o[NUM_CH-1:1] & $past(alarm_i)) == $past(alarm_i)));

  p_latch_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_reset_i |=> ((fault_latched_o & $past(fault_latched_o)) == $past(fault_latched_o)));

  p_reset_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fault_reset_i |=> (fault_latched_o == '0));

  p_claim_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!fo_active_o && (|fault_latched_o) && !fo_reset_i) |=> (fo_active_o && (|first_out_o)));

  p_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fo_active_o && !fo_reset_i) |=> $stable(first_out_o));

  p_fo_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fo_reset_i |=> (first_out_o == '0 && !fo_active_o && !trip_o));

  p_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(first_out_o));

  p_trip_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trip_o == fo_active_o);
endmodule

bind fo_annunciator fo_annunciator_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .run_cmd_i       (run_cmd_i),
  .run_proof_i     (run_proof_i),
  .alarm_i         (alarm_i),
  .fault_reset_i   (fault_reset_i),
  .fo_reset_i      (fo_reset_i),
  .fault_latched_o (fault_latched_o),
  .first_out_o     (first_out_o),
  .fo_active_o     (fo_active_o),
  .trip_o          (trip_o)
);

// File: tb/fo_annunciator_tb.sv
`timescale 1ns/1ps
module fo_annunciator_tb;
  localparam int unsigned NUM_CH = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              run_cmd_i = 1'b0;
  logic              run_proof_i = 1'b1;
  logic [NUM_CH-2:0] alarm_i = '0;
  logic              fault_reset_i = 1'b0;
  logic              fo_reset_i = 1'b0;
  logic [NUM_CH-1:0] fault_latched_o;
  logic [NUM_CH-1:0] first_out_o;
  logic              fo_active_o;
  logic              trip_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fo_annunciator #(.NUM_CH(NUM_CH)) u_dut (
    .clk(clk), .rst_n(rst_n), .run_cmd_i(run_cmd_i), .run_proof_i(run_proof_i),
    .alarm_i(alarm_i), .fault_reset_i(fault_reset_i), .fo_reset_i(fo_reset_i),
    .fault_latched_o(fault_latched_o), .first_out_o(first_out_o),
    .fo_active_o(fo_active_o), .trip_o(trip_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clear_all();
    fault_reset_i = 1'b1; fo_reset_i = 1'b1;
    tick();
    fault_reset_i = 1'b0; fo_reset_i = 1'b0;
  endtask

  function automatic int lowest(input int v);
    return v & (~v + 1);
  endfunction

  initial begin
    #500000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick();
    // R10: reset state
    chk("R10 fault", fault_latched_o, 0);
    chk("R10 first", first_out_o, 0);
    chk("R10 trip", {fo_active_o, trip_o}, 0);
    rst_n = 1'b1;
    run_cmd_i = 1'b1; run_proof_i = 1'b1;
    tick();
    chk("R1 proven run no fault", fault_latched_o, 0);

    // R2 R4 R7 R8: all single-cycle patterns
    for (int p = 0; p < 16; p++) begin
      run_proof_i = !p[0];
      alarm_i = p[3:1];
      tick();
      chk("R2 capture", fault_latched_o, p);
      chk("R4 no claim yet", fo_active_o, 0);
      run_proof_i = 1'b1; alarm_i = '0;
      tick();
      chk("R3 held", fault_latched_o, p);
      chk("R7 lowest wins", first_out_o, lowest(p));
      chk("R4 active", fo_active_o, (p != 0) ? 1 : 0);
      chk("R8 trip", trip_o, (p != 0) ? 1 : 0);
      tick();
      chk("R5 stable", first_out_o, lowest(p));
      clear_all();
      tick();
      chk("R6 cleared", {fault_latched_o, first_out_o, fo_active_o}, 0);
    end

    // R1: no proof fault without run command
    run_cmd_i = 1'b0; run_proof_i = 1'b0;
    tick(); tick();
    chk("R1 unqualified", fault_latched_o, 0);
    run_cmd_i = 1'b1; run_proof_i = 1'b1;

    // R5: later alarms cannot displace cause
    alarm_i = 3'b010; tick(); alarm_i = '0; tick();
    chk("R5 first cause", first_out_o, 4'b0100);
    alarm_i = 3'b001; tick(); alarm_i = '0;
    run_proof_i = 1'b0; tick(); run_proof_i = 1'b1; tick();
    chk("R5 later latches", fault_latched_o, 4'b0111);
    chk("R5 cause kept", first_out_o, 4'b0100);
    clear_all(); tick();

    // R3: reset wins over coincident fault
    alarm_i = 3'b001; fault_reset_i = 1'b1;
    tick();
    chk("R3 reset wins", fault_latched_o, 0);
    fault_reset_i = 1'b0;
    tick();
    chk("R3 latch next edge", fault_latched_o, 4'b0010);
    alarm_i = '0;
    tick();
    chk("R4 claim", first_out_o, 4'b0010);

    // R6: first-out reset leaves latch, re-claims next edge
    fo_reset_i = 1'b1;
    tick();
    chk("R6 fo cleared", {first_out_o, fo_active_o, trip_o}, 0);
    chk("R6 latch kept", fault_latched_o, 4'b0010);
    fo_reset_i = 1'b0;
    tick();
    chk("R6 reclaim", first_out_o, 4'b0010);
    clear_all(); tick();

    // R9: proof toggling every cycle
    run_cmd_i = 1'b1;
    for (int i = 0; i < 20; i++) begin
      run_proof_i = i[0];
      tick();
      chk("R9 captured", fault_latched_o[0], 1);
      if (i > 0) chk("R9 first out", first_out_o, 4'b0001);
    end
    run_proof_i = 1'b1;

    // R10: asynchronous reset mid-cycle
    #1 rst_n = 1'b0;
    #0.5;
    chk("R10 async", {fault_latched_o, first_out_o, fo_active_o, trip_o}, 0);
    tick();
    rst_n = 1'b1;
    tick();

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule